// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a bus target for a two-wire serial bus. It answers one fixed 7-bit address and moves bytes between the bus and a local user. A bus master starts every exchange. The user side cannot start one. It only places bytes in a one-entry transmit holding register and takes bytes from a one-entry receive buffer.

When the master reads and no transmit byte is waiting, the target raises a request flag. It holds the clock line low until the user supplies a byte. A byte loaded ahead of time, while the target is idle or still decoding the address, goes out with no stretching. The holding register empties as soon as the byte moves into the shifter, so the user can queue a second byte while the first is still being sent. When the master writes a byte and the previous byte has not been taken, the target still clocks the new byte in. It then refuses that byte with a NACK and discards it.

Both bus lines pass through a synchroniser and a glitch filter. START and STOP are recognised as data-line edges while the clock line is high. The lines are open-drain: the block only reports when it wants each line pulled low.

Top module: `i2c_stretch_target`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits, sent most significant bit first, equal OWN_ADDR; bit 0 of that byte is 1 for a read and 0 for a write. For any other address it never pulls SDA low until the next START.
- R2: On a write, each complete byte is acknowledged, appears on rx_byte, and sets status bit 3 (new data), provided status bit 3 was clear when the byte completed.
- R3: Status bit 3 stays set until a one-cycle rx_take pulse, which clears it.
- R4: A written byte that completes while status bit 3 is set is clocked in but answered with NACK, and rx_byte keeps the earlier byte.
- R5: A byte loaded with tx_load while the bus is idle is sent, most significant bit first, on the next read, without SCL being held low.
- R6: When the master reads and the holding register is empty, status bit 2 (data request) goes high and SCL is held low until tx_load. Status bit 2 then drops and the supplied byte is sent.
- R7: After status bit 2 drops, one further byte may be loaded. The next read byte uses it without stretching, and the read after that raises status bit 2 again.
- R8: After the master NACKs a read byte, the target releases SDA and reports idle.
- R9: Status bits 1:0 read 00 when idle, 01 while the address byte and its acknowledge are in progress, and 10 during data bytes. Bits 7:4 always read 0.
- R10: A STOP returns the target to idle with both lines released. User-side activity while idle never drives either bus line.
- R11: A low pulse on SDA shorter than FILT_LEN clock cycles, while SCL is high, is not taken as a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level seen on the bus clock line |
| sda_i | input | 1 | Level seen on the bus data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low (stretch) |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| tx_byte | input | 8 | Byte offered for transmission |
| tx_load | input | 1 | One-cycle strobe that offers tx_byte |
| rx_byte | output | 8 | Most recently accepted received byte |
| rx_take | input | 1 | One-cycle strobe marking rx_byte as consumed |
| status | output | 8 | {4'b0, new data, data request, mode[1:0]} |

## Verification
The hardest case to reach is the two-byte read with no request in between. The second byte has to be loaded in the short window after the request flag falls and before the shifter asks for the next byte. The bench models the master as open-drain with a wired-AND bus and waits while the target holds the clock low. During that stretch it supplies the first byte and, one cycle later, the second. It then measures how long each later clock release was held back, which shows that the second byte went out unstretched and the third was stretched again.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_RX       = 3'd3,
        ST_RX_ACK   = 3'd4,
        ST_TX       = 3'd5,
        ST_TX_ACK   = 3'd6,
        ST_WAIT     = 3'd7
    } tgt_state_e;

    localparam logic [1:0] MODE_IDLE = 2'b00;
    localparam logic [1:0] MODE_ADDR = 2'b01;
    localparam logic [1:0] MODE_DATA = 2'b10;

    typedef struct packed {
        tgt_state_e  st;
        logic [3:0]  bits;
        logic [7:0]  sh;
        logic        rw;
        logic        mnack;
        logic        sda_low;
        logic        scl_low;
        logic [7:0]  hold;
        logic        hold_full;
        logic        req;
        logic [7:0]  rxbuf;
        logic        newd;
    } eng_regs_t;

    function automatic logic [1:0] mode_of(tgt_state_e s);
        case (s)
            ST_IDLE:              return MODE_IDLE;
            ST_ADDR, ST_ADDR_ACK: return MODE_ADDR;
            default:              return MODE_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   out;
    } flt_t;

    flt_t r_d, r_q;
    logic sample;

    assign sample = r_q.sync[SYNC_STAGES-1];

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[SYNC_STAGES-2:0], line_i};
        if (sample == r_q.out) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(FILT_LEN - 1)) begin
            r_d.out = sample;
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sync <= '1;
            r_q.cnt  <= '0;
            r_q.out  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_o = r_q.out;

    // R11: the filtered level only moves toward the synchronised sample
    p_filter_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(sample) == line_o));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } evt_t;

    evt_t r_d, r_q;

    always_comb begin
        r_d.scl_p = scl_f;
        r_d.sda_p = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;
        else        r_q <= r_d;
    end

    assign scl_rise = scl_f & ~r_q.scl_p;
    assign scl_fall = ~scl_f & r_q.scl_p;
    assign ev_start = scl_f & r_q.scl_p & r_q.sda_p & ~sda_f;
    assign ev_stop  = scl_f & r_q.scl_p & ~r_q.sda_p & sda_f;

    p_start_stop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_start && ev_stop));

endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic [7:0] tx_byte,
    input  logic       tx_load,
    input  logic       rx_take,
    output logic [7:0] rx_byte,
    output logic       scl_low_o,
    output logic       sda_low_o,
    output logic [7:0] status_o
);
    eng_regs_t r_d, r_q;
    logic      begin_tx;

    always_comb begin
        r_d      = r_q;
        begin_tx = 1'b0;

        if (rx_take) r_d.newd = 1'b0;

        if (tx_load && !r_q.hold_full && r_q.st != ST_WAIT) begin
            r_d.hold      = tx_byte;
            r_d.hold_full = 1'b1;
        end

        if (ev_start || ev_stop) begin
            r_d.st      = ev_start ? ST_ADDR : ST_IDLE;
            r_d.bits    = 4'd0;
            r_d.sda_low = 1'b0;
            r_d.scl_low = 1'b0;
            r_d.req     = 1'b0;
        end else begin
            case (r_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.sh   = {r_q.sh[6:0], sda_lvl};
                        r_d.bits = r_q.bits + 4'd1;
                    end else if (scl_fall && r_q.bits == 4'd8) begin
                        r_d.bits = 4'd0;
                        if (r_q.sh[7:1] == OWN_ADDR) begin
                            r_d.st      = ST_ADDR_ACK;
                            r_d.rw      = r_q.sh[0];
                            r_d.sda_low = 1'b1;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.sda_low = 1'b0;
                        if (r_q.rw) begin
                            begin_tx = 1'b1;
                        end else begin
                            r_d.st   = ST_RX;
                            r_d.bits = 4'd0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.sh   = {r_q.sh[6:0], sda_lvl};
                        r_d.bits = r_q.bits + 4'd1;
                    end else if (scl_fall && r_q.bits == 4'd8) begin
                        r_d.bits = 4'd0;
                        r_d.st   = ST_RX_ACK;
                        if (!r_q.newd) begin
                            r_d.rxbuf   = r_q.sh;
                            r_d.newd    = 1'b1;
                            r_d.sda_low = 1'b1;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        r_d.sda_low = 1'b0;
                        r_d.st      = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.bits == 4'd7) begin
                            r_d.sda_low = 1'b0;
                            r_d.st      = ST_TX_ACK;
                        end else begin
                            r_d.bits    = r_q.bits + 4'd1;
                            r_d.sh      = {r_q.sh[6:0], 1'b0};
                            r_d.sda_low = ~r_q.sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        r_d.mnack = sda_lvl;
                    end else if (scl_fall) begin
                        if (r_q.mnack) r_d.st = ST_IDLE;
                        else           begin_tx = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (r_q.hold_full || tx_load) begin
                        r_d.sh        = r_q.hold_full ? r_q.hold : tx_byte;
                        r_d.sda_low   = r_q.hold_full ? ~r_q.hold[7] : ~tx_byte[7];
                        r_d.hold_full = 1'b0;
                        r_d.scl_low   = 1'b0;
                        r_d.req       = 1'b0;
                        r_d.bits      = 4'd0;
                        r_d.st        = ST_TX;
                    end
                end
                default: ;
            endcase
        end

        if (begin_tx) begin
            r_d.bits = 4'd0;
            if (r_q.hold_full) begin
                r_d.sh        = r_q.hold;
                r_d.hold_full = 1'b0;
                r_d.sda_low   = ~r_q.hold[7];
                r_d.st        = ST_TX;
            end else begin
                r_d.st      = ST_WAIT;
                r_d.req     = 1'b1;
                r_d.scl_low = 1'b1;
                r_d.sda_low = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_byte   = r_q.rxbuf;
    assign scl_low_o = r_q.scl_low;
    assign sda_low_o = r_q.sda_low;
    assign status_o  = {4'b0000, r_q.newd, r_q.req, mode_of(r_q.st)};

    // R6: a pending request persists until the user supplies a byte
    p_req_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && !tx_load && !r_q.hold_full && !ev_start && !ev_stop) |=> r_q.req);

    // R6: waiting for transmit data always stretches the clock and flags it
    p_wait_stretches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) |-> (scl_low_o && status_o[2]));

    // R3: new-data flag is sticky until consumed
    p_newd_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.newd && !rx_take) |=> r_q.newd);

    // R4: an unread receive buffer is never overwritten
    p_rxbuf_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.newd |=> $stable(r_q.rxbuf));

    // R10: idle never drives either bus line
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (!sda_low_o && !scl_low_o));

endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target #(
    parameter logic [6:0] OWN_ADDR    = 7'h42,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic [7:0] tx_byte,
    input  logic       tx_load,
    output logic [7:0] rx_byte,
    input  logic       rx_take,
    output logic [7:0] status
);
    localparam int N_LINES = 2;
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic scl_rise, scl_fall, ev_start, ev_stop;

    assign raw_lines[IDX_SCL] = scl_i;
    assign raw_lines[IDX_SDA] = sda_i;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    i2c_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (clean_lines[IDX_SCL]),
        .sda_f    (clean_lines[IDX_SDA]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    i2c_target_engine #(
        .OWN_ADDR (OWN_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (clean_lines[IDX_SDA]),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .tx_byte   (tx_byte),
        .tx_load   (tx_load),
        .rx_take   (rx_take),
        .rx_byte   (rx_byte),
        .scl_low_o (scl_drive_low),
        .sda_low_o (sda_drive_low),
        .status_o  (status)
    );

endmodule

// File: tb/test_i2c_stretch_target.sv
module test_i2c_stretch_target;

    localparam logic [6:0] ADDR = 7'h42;
    localparam int Q = 20;
    localparam int FEED_DELAY = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       scl_bus, sda_bus;
    logic       scl_drive_low, sda_drive_low;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_load = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_take = 1'b0;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    int sda_seen = 0;
    int scl_seen = 0;
    int last_stretch = 0;
    int byte_stretch = 0;
    logic       feed_armed = 1'b0;
    logic [7:0] feed_byte = 8'h00;
    logic       feed_next_armed = 1'b0;
    logic [7:0] feed_next = 8'h00;

    always #4 clk = ~clk;

    assign scl_bus = m_scl & ~scl_drive_low;
    assign sda_bus = m_sda & ~sda_drive_low;

    i2c_stretch_target #(.OWN_ADDR(ADDR)) i_i2c_stretch_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_bus),
        .sda_i         (sda_bus),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .tx_byte       (tx_byte),
        .tx_load       (tx_load),
        .rx_byte       (rx_byte),
        .rx_take       (rx_take),
        .status        (status)
    );

    always @(negedge clk) begin
        if (sda_drive_low) sda_seen++;
        if (scl_drive_low) scl_seen++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_load(input logic [7:0] v);
        tx_byte = v;
        tx_load = 1'b1;
        tick(1);
        tx_load = 1'b0;
    endtask

    task automatic pulse_take();
        rx_take = 1'b1;
        tick(1);
        rx_take = 1'b0;
    endtask

    task automatic scl_release();
        int n = 0;
        m_scl = 1'b1;
        tick(1);
        while (scl_bus !== 1'b1) begin
            if (feed_armed && n == FEED_DELAY) begin
                chk("R6", int'(status[2]), 1, "data request during stretch");
                chk("R6", int'(scl_drive_low), 1, "clock held low while waiting");
                feed_armed = 1'b0;
                pulse_load(feed_byte);
                chk("R6", int'(status[2]), 0, "data request drops on load");
                if (feed_next_armed) begin
                    feed_next_armed = 1'b0;
                    pulse_load(feed_next);
                end
                n += (feed_next_armed ? 2 : 1);
            end
            n++;
            tick(1);
        end
        last_stretch = n;
    endtask

    task automatic m_start();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tick(Q);
        scl_release(); tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic m_bit_wr(input logic b);
        m_sda = b; tick(Q);
        scl_release(); tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_bit_rd(output logic b);
        m_sda = 1'b1; tick(Q);
        scl_release();
        if (last_stretch > byte_stretch) byte_stretch = last_stretch;
        tick(Q / 2);
        b = sda_bus;
        tick(Q / 2);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_byte_wr(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_wr(d[i]);
        m_bit_rd(b);
        acked = ~b;
    endtask

    task automatic m_byte_rd(input logic ack, output logic [7:0] d);
        logic b;
        byte_stretch = 0;
        for (int i = 7; i >= 0; i--) begin
            m_bit_rd(b);
            d[i] = b;
        end
        m_bit_wr(~ack);
    endtask

    task automatic t_reset();
        chk("R9", int'(status), 0, "status after reset");
        chk("R10", int'(scl_drive_low), 0, "scl released after reset");
        chk("R10", int'(sda_drive_low), 0, "sda released after reset");
        chk("R2", int'(rx_byte), 0, "rx_byte after reset");
    endtask

    task automatic t_glitch();
        m_sda = 1'b0; tick(2);
        m_sda = 1'b1; tick(2 * Q);
        chk("R11", int'(status[1:0]), 0, "short sda pulse is not a start");
        chk("R11", sda_seen + scl_seen, 0, "no line driven after glitch");
    endtask

    task automatic t_wrong_addr();
        logic ack;
        sda_seen = 0;
        m_start();
        m_byte_wr({ADDR + 7'd1, 1'b0}, ack);
        chk("R1", int'(ack), 0, "foreign address not acknowledged");
        m_byte_wr(8'h00, ack);
        chk("R1", int'(ack), 0, "following byte not acknowledged");
        m_stop();
        chk("R1", sda_seen, 0, "sda never driven for foreign address");
    endtask

    task automatic t_write();
        logic ack;
        m_start();
        chk("R9", int'(status[1:0]), 1, "mode during address");
        m_byte_wr({ADDR, 1'b0}, ack);
        chk("R1", int'(ack), 1, "own address acknowledged");
        chk("R9", int'(status[1:0]), 2, "mode during data");
        m_byte_wr(8'hA5, ack);
        chk("R2", int'(ack), 1, "first byte acknowledged");
        chk("R2", int'(rx_byte), 8'hA5, "first byte in buffer");
        chk("R2", int'(status[3]), 1, "new data set");
        m_byte_wr(8'h3C, ack);
        chk("R4", int'(ack), 0, "overrun byte refused");
        chk("R4", int'(rx_byte), 8'hA5, "buffer kept on overrun");
        chk("R3", int'(status[3]), 1, "new data still set before take");
        pulse_take();
        chk("R3", int'(status[3]), 0, "new data cleared by take");
        m_byte_wr(8'h5A, ack);
        chk("R2", int'(ack), 1, "byte after take acknowledged");
        chk("R2", int'(rx_byte), 8'h5A, "byte after take stored");
        pulse_take();
        m_stop();
        chk("R10", int'(status[1:0]), 0, "idle after stop");
        chk("R10", int'(sda_drive_low | scl_drive_low), 0, "lines released after stop");
        chk("R9", int'(status[7:4]), 0, "upper status bits zero");
    endtask

    task automatic t_preload();
        logic ack;
        logic [7:0] d;
        sda_seen = 0;
        scl_seen = 0;
        pulse_load(8'hC3);
        tick(10 * Q);
        chk("R10", sda_seen + scl_seen, 0, "load while idle drives nothing");
        chk("R10", int'(status), 0, "status idle after load");
        m_start();
        m_byte_wr({ADDR, 1'b1}, ack);
        chk("R1", int'(ack), 1, "read address acknowledged");
        m_byte_rd(1'b0, d);
        chk("R5", int'(d), 8'hC3, "preloaded byte sent");
        chk("R5", byte_stretch, 0, "no stretch with preload");
        chk("R8", int'(sda_drive_low), 0, "sda released after master nack");
        chk("R8", int'(status[1:0]), 0, "idle after master nack");
        m_stop();
    endtask

    task automatic t_stretch_read();
        logic ack;
        logic [7:0] d;
        feed_byte = 8'h96;
        feed_next = 8'h3E;
        feed_armed = 1'b1;
        feed_next_armed = 1'b1;
        m_start();
        m_byte_wr({ADDR, 1'b1}, ack);
        chk("R1", int'(ack), 1, "read address acknowledged");
        m_byte_rd(1'b1, d);
        chk("R6", int'(d), 8'h96, "stretched byte sent");
        chk("R6", int'(byte_stretch > 0), 1, "clock was stretched");
        m_byte_rd(1'b1, d);
        chk("R7", int'(d), 8'h3E, "queued second byte sent");
        chk("R7", byte_stretch, 0, "second byte not stretched");
        feed_byte = 8'h71;
        feed_armed = 1'b1;
        m_byte_rd(1'b0, d);
        chk("R7", int'(d), 8'h71, "third byte after new request");
        chk("R7", int'(byte_stretch > 0), 1, "third byte stretched");
        chk("R8", int'(sda_drive_low), 0, "sda released after final nack");
        m_stop();
        chk("R10", int'(status), 0, "status idle at end");
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_glitch();
        t_wrong_addr();
        t_write();
        t_preload();
        t_stretch_read();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule